// File: doc/BRIEF.md
# Region-Based Memory Protection Unit

This block checks every memory access against eight regions programmed by software. Each region holds the following:

- a base address
- a power-of-two size, from 4 KB up to the full 4 GB space
- an enable bit
- a cacheable attribute
- a bufferable attribute
- a two-bit permission code

An access arrives with its address, a write flag and a privilege flag. One cycle later the unit returns one of two results. If the access may proceed, it returns the cache and write-buffer attributes of the region that governs the address. Otherwise it flags an abort.

The regions may overlap. Where they do, the region with the higher index decides, so that a small window can be carved out of a large one. An address that no enabled region covers is refused.

Software writes one region at a time through a single write port. The port takes a region index and a 32-bit configuration word. The new setting applies to any access presented in the cycle that follows the write.

Top module: `mpu_region_check`

## Requirements
- R1: There are eight regions, written through `cfg_we`/`cfg_idx`/`cfg_wdata`. The configuration word is laid out as follows: bits [31:12] base, [11:7] size code, [6:5] permission, [4] bufferable, [3] cacheable, [2] enable; bits [1:0] are ignored. A write at one clock edge governs an access presented in the very next cycle.
- R2: Reset clears every region's enable bit, so every access after reset aborts until a region is enabled.
- R3: Size code k selects a region of 2^(12+k) bytes. Any code of 20 or more means the whole 4 GB space. An address hits a region when its bits from 12+k upward equal the base's bits from 12+k upward; base bits below 12+k are ignored.
- R4: When several enabled regions hit, the highest-numbered one alone decides the permission and attributes, even if a lower region would allow the access.
- R5: An access that hits no enabled region aborts, and `rsp_region` reads 0.
- R6: Permission codes work as follows. Code 0 refuses every access. Code 1 allows privileged accesses only. Code 2 allows privileged reads and writes, but user reads only. Code 3 allows everything. A refused access aborts.
- R7: On an allowed access `rsp_cacheable`/`rsp_bufferable` carry the winning region's bits. On an abort both are 0. `rsp_region` gives the winning region whenever one hits, including on a permission abort.
- R8: `rsp_valid` is high exactly in the cycle after `acc_valid` was high. In every other cycle all response outputs are 0.
- R9: A region whose enable bit is 0 is ignored even where its range covers the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Region configuration write strobe |
| cfg_idx | input | 3 | Region written |
| cfg_wdata | input | 32 | Configuration word (layout in R1) |
| acc_valid | input | 1 | Access presented this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | 1 = privileged, 0 = user |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_abort | output | 1 | Access refused |
| rsp_cacheable | output | 1 | Winning region's cacheable bit |
| rsp_bufferable | output | 1 | Winning region's bufferable bit |
| rsp_region | output | 3 | Winning region index |

## Verification
A configuration write takes effect one edge after it is strobed. A response appears one edge after its access is presented. The bench therefore drives each input on a falling edge, lets exactly one rising edge pass, and samples on the following falling edge. It issues an access in the cycle right after a write, so that the one-cycle effect of R1 is tested rather than assumed. After each sampled response it holds `acc_valid` low for one more cycle and checks that every response output has returned to 0.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

    localparam int NUM_REGIONS = 8;
    localparam int ADDR_W      = 32;
    localparam int MIN_SHIFT   = 12;
    localparam int SIZE_W      = 5;
    localparam int IDX_W       = $clog2(NUM_REGIONS);
    localparam int PAGE_W      = ADDR_W - MIN_SHIFT;

    // configuration word bit positions
    localparam int F_SIZE_LO = 7;
    localparam int F_PERM_LO = 5;
    localparam int F_BUF     = 4;
    localparam int F_CACHE   = 3;
    localparam int F_EN      = 2;

    typedef enum logic [1:0] {
        PERM_NONE    = 2'd0,
        PERM_PRIV    = 2'd1,
        PERM_USER_RO = 2'd2,
        PERM_FULL    = 2'd3
    } perm_e;

    typedef struct packed {
        logic [PAGE_W-1:0] base;
        logic [SIZE_W-1:0] size_code;
        perm_e             perm;
        logic              bufferable;
        logic              cacheable;
        logic              enable;
    } region_t;

    typedef struct packed {
        logic             valid;
        logic             abort;
        logic             cacheable;
        logic             bufferable;
        logic [IDX_W-1:0] region;
    } resp_t;

    function automatic region_t decode_cfg(input logic [ADDR_W-1:0] w);
        region_t r;
        r.base       = w[ADDR_W-1:MIN_SHIFT];
        r.size_code  = w[F_SIZE_LO +: SIZE_W];
        r.perm       = perm_e'(w[F_PERM_LO +: 2]);
        r.bufferable = w[F_BUF];
        r.cacheable  = w[F_CACHE];
        r.enable     = w[F_EN];
        return r;
    endfunction

    // page bits that take part in the compare: those at or above the size code
    function automatic logic [PAGE_W-1:0] cmp_mask(input logic [SIZE_W-1:0] code);
        logic [PAGE_W-1:0] m;
        for (int i = 0; i < PAGE_W; i++) begin
            m[i] = (i >= int'(code));
        end
        return m;
    endfunction

    function automatic logic perm_allows(input perm_e p, input logic priv, input logic wr);
        case (p)
            PERM_NONE:    return 1'b0;
            PERM_PRIV:    return priv;
            PERM_USER_RO: return priv | ~wr;
            default:      return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/mpu_region_regs.sv
module mpu_region_regs
    import mpu_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [IDX_W-1:0]        idx,
    input  logic [ADDR_W-1:0]       wdata,
    output region_t                 regions [NUM_REGIONS]
);

    region_t new_cfg;
    assign new_cfg = decode_cfg(wdata);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regions[g] <= '0;
            end else if (we && (idx == IDX_W'(g))) begin
                regions[g] <= new_cfg;
            end
        end
    end

endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
    import mpu_pkg::*;
(
    input  region_t                 regions [NUM_REGIONS],
    input  logic [PAGE_W-1:0]       page,
    output logic [NUM_REGIONS-1:0]  hit
);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
        logic [PAGE_W-1:0] mask;
        assign mask   = cmp_mask(regions[g].size_code);
        assign hit[g] = regions[g].enable &&
                        (((page ^ regions[g].base) & mask) == '0);
    end

endmodule

// File: rtl/mpu_priority_select.sv
module mpu_priority_select
    import mpu_pkg::*;
(
    input  logic [NUM_REGIONS-1:0]  hit,
    output logic                    found,
    output logic [IDX_W-1:0]        winner
);

    always_comb begin
        found  = 1'b0;
        winner = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hit[i]) begin
                found  = 1'b1;
                winner = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/mpu_region_check.sv
module mpu_region_check
    import mpu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_idx,
    input  logic [31:0] cfg_wdata,
    input  logic        acc_valid,
    input  logic [31:0] acc_addr,
    input  logic        acc_write,
    input  logic        acc_priv,
    output logic        rsp_valid,
    output logic        rsp_abort,
    output logic        rsp_cacheable,
    output logic        rsp_bufferable,
    output logic [2:0]  rsp_region
);

    region_t                regions [NUM_REGIONS];
    logic [NUM_REGIONS-1:0] hit;
    logic                   found;
    logic [IDX_W-1:0]       winner;
    region_t                sel;
    logic                   allowed;
    resp_t                  nxt;
    resp_t                  rsp_q;
    logic                   addr_unused;
    logic                   cfg_unused;

    assign addr_unused = ^acc_addr[MIN_SHIFT-1:0];
    assign cfg_unused  = ^cfg_wdata[1:0];

    mpu_region_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .idx     (cfg_idx),
        .wdata   (cfg_wdata),
        .regions (regions)
    );

    mpu_region_match u_match (
        .regions (regions),
        .page    (acc_addr[ADDR_W-1:MIN_SHIFT]),
        .hit     (hit)
    );

    mpu_priority_select u_sel (
        .hit    (hit),
        .found  (found),
        .winner (winner)
    );

    assign sel     = regions[winner];
    assign allowed = found && perm_allows(sel.perm, acc_priv, acc_write);

    always_comb begin
        nxt            = '0;
        nxt.valid      = acc_valid;
        if (acc_valid) begin
            nxt.abort      = ~allowed;
            nxt.cacheable  = allowed & sel.cacheable;
            nxt.bufferable = allowed & sel.bufferable;
            nxt.region     = found ? winner : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= nxt;
    end

    assign rsp_valid      = rsp_q.valid;
    assign rsp_abort      = rsp_q.abort;
    assign rsp_cacheable  = rsp_q.cacheable;
    assign rsp_bufferable = rsp_q.bufferable;
    assign rsp_region     = rsp_q.region;

endmodule

// File: rtl/mpu_region_check_sva.sv
module mpu_region_check_sva (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic        acc_valid,
    input logic        rsp_valid,
    input logic        rsp_abort,
    input logic        rsp_cacheable,
    input logic        rsp_bufferable,
    input logic [2:0]  rsp_region
);

    logic cfg_seen;

    always_ff @(posedge clk) begin
        if (rst)         cfg_seen <= 1'b0;
        else if (cfg_we) cfg_seen <= 1'b1;
    end

    // R8: a response follows each access by exactly one cycle
    assert_rsp_after_acc_R8: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> rsp_valid);

    assert_no_rsp_without_acc_R8: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !rsp_valid);

    // R8: idle outputs are zero
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_abort && !rsp_cacheable && !rsp_bufferable && rsp_region == 3'd0));

    // R7: an abort carries no attributes
    assert_abort_no_attr_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_abort) |-> (!rsp_cacheable && !rsp_bufferable));

    // R2: until any region is written, every access aborts
    assert_reset_disabled_R2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !cfg_seen) |=> rsp_abort);

endmodule

bind mpu_region_check mpu_region_check_sva u_sva (
    .clk            (clk),
    .rst            (rst),
    .cfg_we         (cfg_we),
    .acc_valid      (acc_valid),
    .rsp_valid      (rsp_valid),
    .rsp_abort      (rsp_abort),
    .rsp_cacheable  (rsp_cacheable),
    .rsp_bufferable (rsp_bufferable),
    .rsp_region     (rsp_region)
);

// File: tb/mpu_region_check_bench.sv
module mpu_region_check_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        acc_priv = 1'b0;
    logic        rsp_valid, rsp_abort, rsp_cacheable, rsp_bufferable;
    logic [2:0]  rsp_region;

    int errors = 0;
    int checks = 0;
    logic [31:0] shadow [8];

    always #5 clk = ~clk;

    mpu_region_check u_mpu_region_check (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write), .acc_priv(acc_priv),
        .rsp_valid(rsp_valid), .rsp_abort(rsp_abort), .rsp_cacheable(rsp_cacheable),
        .rsp_bufferable(rsp_bufferable), .rsp_region(rsp_region)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mkcfg(input logic [31:0] base, input int code, input int perm,
                                          input bit bufb, input bit cach, input bit en);
        return {base[31:12], 5'(code), 2'(perm), bufb, cach, en, 2'b00};
    endfunction

    // expected response computed from the requirement text
    task automatic model(input logic [31:0] addr, input bit wr, input bit priv,
                         output bit ab, output bit c, output bit b, output int reg_o);
        bit found = 0;
        int w = 0;
        for (int i = 0; i < 8; i++) begin
            longint unsigned sz, lo;
            int k;
            k  = int'(shadow[i][11:7]);
            if (k > 20) k = 20;
            sz = 64'd1 << (12 + k);
            lo = {32'd0, shadow[i][31:12], 12'd0} & ~(sz - 1);
            if (shadow[i][2] && {32'd0, addr} >= lo && {32'd0, addr} < lo + sz) begin
                found = 1; w = i;
            end
        end
        reg_o = found ? w : 0;
        ab = 1; c = 0; b = 0;
        if (found) begin
            int p = int'(shadow[w][6:5]);
            bit ok = (p == 3) || (p == 1 && priv) || (p == 2 && (priv || !wr));
            if (ok) begin ab = 0; c = shadow[w][3]; b = shadow[w][4]; end
        end
    endtask

    task automatic cfg_write(input int idx, input logic [31:0] word);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = word;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
        shadow[idx] = word;
    endtask

    task automatic access(input string req, input logic [31:0] addr, input bit wr, input bit priv);
        bit ab, c, b; int r;
        model(addr, wr, priv, ab, c, b, r);
        acc_valid = 1'b1; acc_addr = addr; acc_write = wr; acc_priv = priv;
        @(posedge clk); @(negedge clk);
        acc_valid = 1'b0;
        check(req, "R8 rsp_valid", 32'(rsp_valid), 32'd1);
        check(req, "abort", 32'(rsp_abort), 32'(ab));
        check(req, "R7 cacheable", 32'(rsp_cacheable), 32'(c));
        check(req, "R7 bufferable", 32'(rsp_bufferable), 32'(b));
        check(req, "region", 32'(rsp_region), 32'(r));
        @(posedge clk); @(negedge clk);
        check("R8", "idle outputs", {rsp_valid, rsp_abort, rsp_cacheable, rsp_bufferable, rsp_region},
              32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 8; i++) shadow[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        check("R8", "reset rsp_valid", 32'(rsp_valid), 32'd0);
        access("R2 R5 all disabled after reset", 32'h0000_0000, 0, 1);
        access("R2 R5 all disabled after reset", 32'hFFFF_F000, 1, 0);

        cfg_write(0, mkcfg(32'h0, 20, 3, 0, 1, 1));
        access("R1 R3 4GB region right after write", 32'hDEAD_BEEF, 1, 0);

        cfg_write(1, mkcfg(32'h4000_0000, 8, 2, 1, 1, 1));
        access("R6 user write to user-ro aborts", 32'h400F_FFFF, 1, 0);
        access("R6 R7 user read user-ro", 32'h4000_0000, 0, 0);
        access("R6 privileged write user-ro", 32'h4008_0000, 1, 1);
        access("R3 first byte past 1MB", 32'h4010_0000, 1, 0);

        cfg_write(5, mkcfg(32'h4008_0000, 0, 0, 0, 0, 1));
        access("R4 higher no-access region wins", 32'h4008_0010, 0, 1);
        access("R3 4KB boundary falls to lower", 32'h4008_1000, 0, 1);
        cfg_write(5, mkcfg(32'h4008_0000, 0, 3, 1, 1, 0));
        access("R9 disabled region ignored", 32'h4008_0010, 1, 1);

        cfg_write(7, mkcfg(32'h8000_0000, 12, 1, 1, 0, 1));
        access("R6 privileged-only user read", 32'h8000_1234, 0, 0);
        access("R6 privileged-only priv write", 32'h80FF_FFFC, 1, 1);

        cfg_write(6, mkcfg(32'h1234_5000, 4, 3, 0, 0, 1));
        access("R3 low base bits ignored", 32'h1234_0000, 1, 0);
        access("R3 end of 64KB", 32'h1234_FFFF, 0, 0);

        cfg_write(0, mkcfg(32'h0, 0, 3, 1, 0, 0));
        access("R5 no region hit", 32'h0000_0040, 0, 1);
        cfg_write(4, mkcfg(32'h0, 25, 0, 0, 0, 1));
        access("R3 code above 20 covers all", 32'h0000_0040, 0, 1);

        for (int it = 0; it < 400; it++) begin
            if (($urandom % 4) == 0) begin
                int code = (($urandom % 8) == 0) ? 20 + int'($urandom % 12) : int'($urandom % 8);
                cfg_write(int'($urandom % 8),
                          mkcfg($urandom, code, int'($urandom % 4), 1'($urandom), 1'($urandom),
                                ($urandom % 4) != 0));
            end
            begin
                int j = int'($urandom % 8);
                int k = int'(shadow[j][11:7]);
                logic [31:0] span;
                if (k > 19) k = 19;
                span = (32'd1 << (13 + k)) - 1;
                access("R4 R6 R7 random", {shadow[j][31:12], 12'd0} ^ ($urandom & span),
                       1'($urandom), 1'($urandom));
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule